// File: doc/BRIEF.md
# Cascaded power-good output sequencer

This block releases four active-low power-good enables, one after another, once the main series switch of a hot-plugged card is judged fully on. The first output follows as soon as the gate-ok and drain-ok flags from the analog front end are both true. Each later output follows a selectable delay after the one before it. Time is counted in ticks of an external microsecond strobe, so a test can shorten or stop time by changing that strobe.

Three cascaded enable inputs gate the later outputs. Enable A covers outputs 2 to 4, enable B covers 3 and 4, and enable C covers output 4 only. Dropping an enable floats its outputs at once. Raising it again lets the chain pick up where it stopped, and the inter-stage delay still applies. Each output has a drive-enable bit that models the open-drain pin: 1 means the pin is pulled low, 0 means it is high impedance. Fault detection lives elsewhere and arrives here only as a shutdown request.

Top module: `pg_sequencer`

## Requirements
- R1: Output 0 (`pg_n[0]` low) asserts on the first clock edge at which `drain_ok` is high and either `gate_ok` is high or the gate-ok latch is set. With `drain_ok` low it stays deasserted.
- R2: Output k (k = 1..3) asserts on the clock edge that samples the L-th `us_tick` pulse counted after output k-1 is asserted. L is the delay chosen by `dly_sel`. With a tick on every cycle this is exactly L cycles after output k-1.
- R3: `dly_sel` codes map to these delays in microsecond ticks: 0 = 50, 1 = 250, 2 = 500, 3 = 1000, 4 = 5000 (the reset value of the configuration field that feeds this input), 5 = 20000, 6 = 80000, 7 = 160000.
- R4: Output 1 needs `en_a`. Output 2 needs `en_a` and `en_b`. Output 3 needs `en_a`, `en_b` and `en_c`. An output whose enables are not all high never asserts.
- R5: When an enable input falls, the outputs it gates go to high impedance in the same cycle, with no clock edge needed. Earlier outputs are unaffected.
- R6: Once `gate_ok` has been seen high, it is latched. A later drop of `gate_ok` neither deasserts output 0 nor stalls the chain.
- R7: At the first clock edge that samples `shutdown` high, all four outputs deassert. They stay off while `shutdown` is high. Shutdown also clears the gate-ok latch, so a restart needs `gate_ok` again.
- R8: When an enable rises again while the predecessor output is on, the first stage it gates asserts L ticks after the rise. The stages after it follow at L-tick spacing.
- R9: Reset gives `pg_n` = 4'b1111 and `pg_oe` = 4'b0000. At all times `pg_oe[k]` is 1 only while `pg_n[k]` is 0.
- R10: Without `us_tick` pulses, no later stage makes progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| gate_ok | input | 1 | Gate voltage has reached its on-threshold |
| drain_ok | input | 1 | Drain-sense voltage is below its threshold |
| en_a | input | 1 | Cascaded enable for outputs 1..3 |
| en_b | input | 1 | Cascaded enable for outputs 2..3 |
| en_c | input | 1 | Cascaded enable for output 3 |
| shutdown | input | 1 | Shutdown request from fault logic |
| dly_sel | input | 3 | Inter-stage delay code |
| pg_n | output | 4 | Active-low power-good enables |
| pg_oe | output | 4 | Drive enable per output (1 = pulled low) |

## Verification
A stage counter that is not cleared or is off by one shows up as a gap between successive falling edges of `pg_n` that differs from L ticks. That error is visible at the very next output of the chain. A stale stage flag after an enable drop or a shutdown appears as an early output on resume, or as an output still driven the cycle after shutdown. A gate-ok latch that is not cleared lets output 0 return after shutdown without `gate_ok`, one edge after `drain_ok`. The bench measures these gaps in cycles, with ticks on every cycle, on every second cycle, and with ticks stopped.

// File: rtl/pg_seq_pkg.sv
// pg_seq_pkg: shared sizing and the delay-code decode for the power-good sequencer.
// Assumes one tick per microsecond; the longest delay sets the counter width.
package pg_seq_pkg;
    localparam int STAGES    = 4;
    localparam int MAX_TICKS = 160000;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam int SEL_W     = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    // Map a delay code to its length in microsecond ticks.
    function automatic cnt_t dly_ticks(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return cnt_t'(50);
            3'd1:    return cnt_t'(250);
            3'd2:    return cnt_t'(500);
            3'd3:    return cnt_t'(1000);
            3'd4:    return cnt_t'(5000);
            3'd5:    return cnt_t'(20000);
            3'd6:    return cnt_t'(80000);
            default: return cnt_t'(MAX_TICKS);
        endcase
    endfunction
endpackage

// File: rtl/pg_head_stage.sv
// pg_head_stage: first output of the chain plus the gate-ok latch.
// Assumes gate_ok and drain_ok are already synchronised; shutdown clears all state.
module pg_head_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_ok,
    input  logic drain_ok,
    input  logic shutdown,
    output logic on_o
);
    logic gate_seen_q;
    logic on_q;

    // Remember that the gate reached its threshold during this turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n || shutdown) gate_seen_q <= 1'b0;
        else if (gate_ok)       gate_seen_q <= 1'b1;
    end

    // Assert the head output once gate and drain conditions hold; hold until shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n || shutdown) on_q <= 1'b0;
        else if (!on_q)         on_q <= (gate_seen_q | gate_ok) & drain_ok;
    end

    assign on_o = on_q;
endmodule

// File: rtl/pg_delay_stage.sv
// pg_delay_stage: one later output of the chain, with its own tick counter.
// Assumes pred_on only falls together with allowed or shutdown; counter restarts per stage.
module pg_delay_stage
    import pg_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pred_on,
    input  logic allowed,
    input  logic shutdown,
    input  cnt_t limit,
    output logic on_o
);
    cnt_t cnt_q;
    logic on_q;
    logic idle;

    assign idle = shutdown | ~allowed | ~pred_on | on_q;

    // Count ticks while waiting; set the stage on the limit-th tick.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q >= limit - cnt_t'(1)) cnt_q <= '0;
            else                            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    // Stage flag: cleared by shutdown or a dropped enable, set when the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n || shutdown || !allowed) on_q <= 1'b0;
        else if (!on_q && pred_on && tick && (cnt_q >= limit - cnt_t'(1))) on_q <= 1'b1;
    end

    assign on_o = on_q;
endmodule

// File: rtl/pg_sequencer.sv
// pg_sequencer: drives four active-low power-good enables in a timed, nested-enable chain.
// Assumes us_tick is a one-cycle strobe; outputs float (pg_oe=0) unless pulled low.
module pg_sequencer
    import pg_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             gate_ok,
    input  logic             drain_ok,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             en_c,
    input  logic             shutdown,
    input  logic [SEL_W-1:0] dly_sel,
    output logic [STAGES-1:0] pg_n,
    output logic [STAGES-1:0] pg_oe
);
    logic [STAGES-1:0] on_w;
    logic [STAGES-1:0] allow;
    logic [STAGES-2:0] en_vec;
    cnt_t              limit;

    assign en_vec = {en_c, en_b, en_a};
    assign limit  = dly_ticks(dly_sel);
    assign allow[0] = 1'b1;

    pg_head_stage head_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_ok  (gate_ok),
        .drain_ok (drain_ok),
        .shutdown (shutdown),
        .on_o     (on_w[0])
    );

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Cumulative enable: a stage needs its own enable and all earlier ones.
        assign allow[k] = allow[k-1] & en_vec[k-1];

        pg_delay_stage stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (us_tick),
            .pred_on  (on_w[k-1]),
            .allowed  (allow[k]),
            .shutdown (shutdown),
            .limit    (limit),
            .on_o     (on_w[k])
        );
    end

    // Enable masking is combinational so a dropped enable floats outputs at once.
    assign pg_oe = on_w & allow;
    assign pg_n  = ~pg_oe;
endmodule

// File: rtl/pg_sequencer_chk.sv
// pg_sequencer_chk: temporal properties of the sequencer ports, bound to the top.
module pg_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       drain_ok,
    input logic       en_a,
    input logic       en_b,
    input logic       en_c,
    input logic       shutdown,
    input logic [3:0] pg_oe
);
    a_r1_head_needs_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_oe[0]) |-> $past(drain_ok));

    a_r2_stage1_after_head: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_oe[1]) |-> $past(pg_oe[0]));

    a_r2_stage2_after_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_oe[2]) |-> $past(pg_oe[1]));

    a_r2_stage3_after_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_oe[3]) |-> $past(pg_oe[2]));

    a_r4_en_a_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !en_a |-> (pg_oe[3:1] == 3'b000));

    a_r4_en_b_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |-> (pg_oe[3:2] == 2'b00));

    a_r4_en_c_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !en_c |-> !pg_oe[3]);

    a_r7_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shutdown) |-> (pg_oe == 4'b0000));
endmodule

bind pg_sequencer pg_sequencer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .drain_ok (drain_ok),
    .en_a     (en_a),
    .en_b     (en_b),
    .en_c     (en_c),
    .shutdown (shutdown),
    .pg_oe    (pg_oe)
);

// File: tb/pg_sequencer_tb_top.sv
`timescale 1ns/100ps
// Directed bench for pg_sequencer: one task per scenario, each checks its own results.
module pg_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       gate_ok = 1'b0, drain_ok = 1'b0;
    logic       en_a = 1'b1, en_b = 1'b1, en_c = 1'b1;
    logic       shutdown = 1'b0;
    logic [2:0] dly_sel = 3'd0;
    logic [3:0] pg_n, pg_oe;

    int n_chk = 0, n_fail = 0;
    int tick_div = 1;
    int tick_ph = 0;

    always #2.5 clk = ~clk;

    pg_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .gate_ok(gate_ok),
        .drain_ok(drain_ok), .en_a(en_a), .en_b(en_b), .en_c(en_c),
        .shutdown(shutdown), .dly_sel(dly_sel), .pg_n(pg_n), .pg_oe(pg_oe)
    );

    // Tick generator: tick_div 0 stops ticks, N gives one tick every N cycles.
    always @(negedge clk) begin
        if (tick_div == 0) begin
            us_tick <= 1'b0;
        end else if (tick_ph >= tick_div - 1) begin
            us_tick <= 1'b1; tick_ph <= 0;
        end else begin
            us_tick <= 1'b0; tick_ph <= tick_ph + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; gate_ok = 1'b0; drain_ok = 1'b0; shutdown = 1'b0;
        en_a = 1'b1; en_b = 1'b1; en_c = 1'b1; tick_div = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Count negedges until output k is driven low (limit caps the wait).
    task automatic wait_low(input int k, input int limit, output int n);
        n = 0;
        while (pg_n[k] !== 1'b0 && n <= limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check(pg_n == 4'b1111, "R9", "pg_n after reset", pg_n, 4'b1111);
        check(pg_oe == 4'b0000, "R9", "pg_oe after reset", pg_oe, 0);
    endtask

    task automatic t_head_conditions();
        int n;
        do_reset();
        gate_ok = 1'b1;
        repeat (20) @(negedge clk);
        check(pg_n[0] == 1'b1, "R1", "head without drain_ok", pg_n[0], 1);
        drain_ok = 1'b1;
        wait_low(0, 10, n);
        check(n == 1, "R1", "edges to head assert", n, 1);
        check(pg_oe == 4'b0001, "R9", "oe with head only", pg_oe, 1);
    endtask

    // Full chain at one tick per cycle; each gap must equal the delay length.
    task automatic t_chain(input logic [2:0] sel, input int len, input string req);
        int n;
        do_reset();
        dly_sel = sel;
        gate_ok = 1'b1; drain_ok = 1'b1;
        wait_low(0, 10, n);
        for (int k = 1; k < 4; k++) begin
            wait_low(k, len + 10, n);
            check(n == len, req, $sformatf("gap to stage %0d", k), n, len);
        end
        check(pg_oe == 4'b1111, "R9", "oe with all stages", pg_oe, 15);
    endtask

    task automatic t_single_gap(input logic [2:0] sel, input int len);
        int n;
        do_reset();
        dly_sel = sel;
        gate_ok = 1'b1; drain_ok = 1'b1;
        wait_low(0, 10, n);
        wait_low(1, len + 10, n);
        check(n == len, "R3", $sformatf("code %0d stage 1 gap", sel), n, len);
    endtask

    task automatic t_slow_tick();
        int n;
        do_reset();
        dly_sel = 3'd0;
        tick_div = 2;
        gate_ok = 1'b1; drain_ok = 1'b1;
        wait_low(1, 200, n);
        wait_low(2, 200, n);
        check(n == 100, "R2", "gap at half tick rate", n, 100);
        wait_low(3, 200, n);
        check(n == 100, "R2", "gap at half tick rate stage 3", n, 100);
    endtask

    task automatic t_no_tick();
        int n;
        do_reset();
        dly_sel = 3'd0;
        tick_div = 0;
        gate_ok = 1'b1; drain_ok = 1'b1;
        repeat (200) @(negedge clk);
        check(pg_n == 4'b1110, "R10", "stalled without ticks", pg_n, 4'b1110);
        tick_div = 1;
        wait_low(1, 100, n);
        check(n >= 50 && n <= 52, "R10", "resume after ticks return", n, 50);
    endtask

    task automatic t_enable_gating();
        int n;
        do_reset();
        dly_sel = 3'd0;
        en_b = 1'b0;
        gate_ok = 1'b1; drain_ok = 1'b1;
        wait_low(1, 70, n);
        check(n <= 52, "R4", "stage 1 with en_b low", pg_n[1], 0);
        repeat (300) @(negedge clk);
        check(pg_n == 4'b1100, "R4", "stages 2,3 held by en_b", pg_n, 4'b1100);
        check(pg_oe[3:2] == 2'b00, "R4", "oe 2,3 with en_b low", pg_oe[3:2], 0);
    endtask

    task automatic t_drop_and_resume();
        int n;
        t_chain(3'd0, 50, "R2");
        @(negedge clk);
        en_a = 1'b0;
        #1;
        check(pg_n == 4'b1110, "R5", "same-cycle release on en_a", pg_n, 4'b1110);
        check(pg_oe == 4'b0001, "R5", "oe after en_a drop", pg_oe, 1);
        repeat (100) @(negedge clk);
        check(pg_n == 4'b1110, "R5", "stays released", pg_n, 4'b1110);
        en_a = 1'b1;
        wait_low(1, 70, n);
        check(n == 50, "R8", "stage 1 after en_a rise", n, 50);
        wait_low(2, 70, n);
        check(n == 50, "R8", "stage 2 after stage 1 resume", n, 50);
        wait_low(3, 70, n);
        check(n == 50, "R8", "stage 3 after stage 2 resume", n, 50);
    endtask

    task automatic t_gate_latch_and_shutdown();
        int n;
        do_reset();
        dly_sel = 3'd0;
        gate_ok = 1'b1; drain_ok = 1'b1;
        wait_low(0, 10, n);
        gate_ok = 1'b0;
        wait_low(3, 200, n);
        check(pg_n == 4'b0000, "R6", "chain completes after gate_ok drop", pg_n, 0);
        shutdown = 1'b1;
        #1;
        check(pg_oe == 4'b1111, "R7", "outputs held before edge", pg_oe, 15);
        @(negedge clk);
        check(pg_n == 4'b1111, "R7", "all off after shutdown edge", pg_n, 15);
        check(pg_oe == 4'b0000, "R7", "oe off after shutdown", pg_oe, 0);
        repeat (20) @(negedge clk);
        check(pg_n == 4'b1111, "R7", "off while shutdown high", pg_n, 15);
        shutdown = 1'b0;
        repeat (20) @(negedge clk);
        check(pg_n[0] == 1'b1, "R7", "latch cleared, no restart", pg_n[0], 1);
        gate_ok = 1'b1;
        wait_low(0, 10, n);
        check(n == 1, "R6", "restart needs gate_ok", n, 1);
    endtask

    task automatic run_all();
        t_reset_state();
        t_head_conditions();
        t_chain(3'd0, 50, "R2");
        t_chain(3'd1, 250, "R3");
        t_single_gap(3'd2, 500);
        t_single_gap(3'd3, 1000);
        t_single_gap(3'd4, 5000);
        t_slow_tick();
        t_no_tick();
        t_enable_gating();
        t_drop_and_resume();
        t_gate_latch_and_shutdown();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule